// File: doc/BRIEF.md
# Miss-Address History Table

This block keeps a short history of last-level-cache miss addresses, grouped by memory region, so that neighbouring prediction engines can study how each region is walked. Every miss address is cut into an upper region tag and a lower in-region offset. The tag is searched in a small fully associative table. If the tag is found, the offset is pushed onto that region's history. If it is not found, a slot is claimed for the new region and the offset becomes its first history element. A free slot is claimed if one exists. Otherwise the region that missed least recently is overwritten.

A combinational lookup port takes a region tag. It returns whether the region is resident, how many offsets it holds, its four newest offsets, and two per-region counters. One counter tracks prefetches issued into the region and the other tracks prefetches that proved useful. Neighbouring logic bumps these counters through two notify strobes that carry a region tag. The block does not form prefetch addresses, and it does not hold any data.

Top module: `miss_history_table`

## Requirements
- R1: A miss address is split so that bits [ADDR_W-1:OFS_W] form the region tag and bits [OFS_W-1:0] form the offset. The defaults are a 64-bit address, an 18-bit offset and a 46-bit tag.
- R2: A miss whose tag is already resident adds its offset as the newest history element of that entry. It claims no new slot, and the entry's counters keep their values.
- R3: A miss whose tag is not resident claims a slot for that tag in the cycle after the miss is presented. The slot holds the new offset as its only history element, has a count of 1, and has both counters at zero. When free slots exist, the lowest-numbered free slot is chosen.
- R4: When every slot is in use, a miss on a new tag replaces the entry whose most recent miss is oldest. Lookups and notifies do not change this recency order.
- R5: Each entry keeps at most DEPTH offsets, and the oldest offset is dropped first. The count saturates at DEPTH. The lookup returns offsets newest first: the newest in look_ofs[OFS_W-1:0], the next in the following OFS_W bits, and so on. Positions beyond the count read as zero.
- R6: The lookup outputs depend only on the current table state and look_tag, with no added cycle. For a tag that is not resident, look_hit is 0 and every other lookup output is 0.
- R7: note_issue increments the issue counter of the resident entry whose tag equals note_tag. The counter stops at its all-ones value.
- R8: note_hit increments the useful-prefetch counter of the resident entry whose tag equals note_tag. The counter stops at its all-ones value.
- R9: A notify for a tag that is not resident changes nothing. If the notified entry is replaced in the same cycle, the new entry's counters start at zero.
- R10: After reset no slot is in use, and every lookup reports a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss address is presented this cycle |
| miss_addr | input | ADDR_W (64) | Miss address |
| look_tag | input | ADDR_W-OFS_W (46) | Region tag to look up |
| look_hit | output | 1 | Looked-up region is resident |
| look_count | output | clog2(DEPTH+1) | Offsets held by the looked-up region |
| look_ofs | output | 4*OFS_W (72) | Four newest offsets, newest in the low bits |
| look_issue_cnt | output | CNT_W (32) | Prefetches issued into the region |
| look_hit_cnt | output | CNT_W (32) | Prefetches into the region that were used |
| note_tag | input | ADDR_W-OFS_W (46) | Region tag addressed by the notify strobes |
| note_issue | input | 1 | Increment the issue counter of note_tag |
| note_hit | input | 1 | Increment the useful-prefetch counter of note_tag |

## Verification
The assertions assume that miss_valid, miss_addr and the notify inputs are known values in every cycle after reset. They also assume that reset is held for at least one clock before traffic starts, so the recency state starts as a complete ordering. The bench holds every input at zero during reset. It then drives fully defined values on every cycle and keeps region tags within a small set, so that replacement, saturation and same-cycle collisions all occur.

// File: rtl/mhist_pkg.sv
package mhist_pkg;

    // Per-entry update selected by the miss path in a given cycle
    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_APPEND = 2'd1,
        UPD_ALLOC  = 2'd2
    } upd_e;

    // Number of history positions presented on the lookup port
    localparam int SHOWN = 4;

endpackage

// File: rtl/mht_match.sv
module mht_match #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 46
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [ENTRIES-1:0]            valid,
    input  logic [TAG_W-1:0]              key,
    output logic [ENTRIES-1:0]            vec,
    output logic                          hit
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign vec[i] = valid[i] && (tags[i] == key);
    end

    assign hit = |vec;

endmodule

// File: rtl/mht_lru.sv
module mht_lru #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               touch,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid,
    output logic [IDX_W-1:0]   victim,
    output logic [ENTRIES-1:0] oldest
);

    // age 0 = most recent; the ages always form a permutation of 0..ENTRIES-1
    logic [ENTRIES-1:0][IDX_W-1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age[i] <= '0;
                else if (age[i] < age[touch_idx])
                    age[i] <= age[i] + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_old
        assign oldest[i] = (age[i] == IDX_W'(ENTRIES - 1));
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid[i] && !found) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++)
                if (oldest[i]) victim = IDX_W'(i);
        end
    end

endmodule

// File: rtl/mht_entry.sv
module mht_entry
    import mhist_pkg::*;
#(
    parameter int TAG_W    = 46,
    parameter int OFS_W    = 18,
    parameter int DEPTH    = 15,
    parameter int CNT_W    = 32,
    localparam int CNTH_W  = $clog2(DEPTH + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  upd_e                            upd,
    input  logic [TAG_W-1:0]                new_tag,
    input  logic [OFS_W-1:0]                new_ofs,
    input  logic                            inc_issue,
    input  logic                            inc_hit,
    output logic                            valid,
    output logic [TAG_W-1:0]                tag,
    output logic [DEPTH-1:0][OFS_W-1:0]     hist,
    output logic [CNTH_W-1:0]               count,
    output logic [CNT_W-1:0]                issue_cnt,
    output logic [CNT_W-1:0]                hit_cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid     <= 1'b0;
            tag       <= '0;
            hist      <= '0;
            count     <= '0;
            issue_cnt <= '0;
            hit_cnt   <= '0;
        end else begin
            case (upd)
                UPD_ALLOC: begin
                    valid     <= 1'b1;
                    tag       <= new_tag;
                    hist      <= '0;
                    hist[0]   <= new_ofs;
                    count     <= CNTH_W'(1);
                    issue_cnt <= '0;
                    hit_cnt   <= '0;
                end
                UPD_APPEND: begin
                    hist <= {hist[DEPTH-2:0], new_ofs};
                    if (count != CNTH_W'(DEPTH)) count <= count + 1'b1;
                end
                default: ;
            endcase
            // a slot being claimed starts its counters at zero
            if (upd != UPD_ALLOC) begin
                if (inc_issue && issue_cnt != '1) issue_cnt <= issue_cnt + 1'b1;
                if (inc_hit && hit_cnt != '1)     hit_cnt   <= hit_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/miss_history_table.sv
module miss_history_table
    import mhist_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int OFS_W   = 18,
    parameter int ENTRIES = 64,
    parameter int DEPTH   = 15,
    parameter int CNT_W   = 32,
    localparam int TAG_W  = ADDR_W - OFS_W,
    localparam int CNTH_W = $clog2(DEPTH + 1),
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    miss_valid,
    input  logic [ADDR_W-1:0]       miss_addr,
    input  logic [TAG_W-1:0]        look_tag,
    output logic                    look_hit,
    output logic [CNTH_W-1:0]       look_count,
    output logic [SHOWN*OFS_W-1:0]  look_ofs,
    output logic [CNT_W-1:0]        look_issue_cnt,
    output logic [CNT_W-1:0]        look_hit_cnt,
    input  logic [TAG_W-1:0]        note_tag,
    input  logic                    note_issue,
    input  logic                    note_hit
);

    logic [TAG_W-1:0] miss_tag;
    logic [OFS_W-1:0] miss_ofs;
    assign miss_tag = miss_addr[ADDR_W-1:OFS_W];
    assign miss_ofs = miss_addr[OFS_W-1:0];

    logic [ENTRIES-1:0]                       valid_vec;
    logic [ENTRIES-1:0][TAG_W-1:0]            tags;
    logic [ENTRIES-1:0][DEPTH-1:0][OFS_W-1:0] hists;
    logic [ENTRIES-1:0][CNTH_W-1:0]           counts;
    logic [ENTRIES-1:0][CNT_W-1:0]            issues;
    logic [ENTRIES-1:0][CNT_W-1:0]            useds;

    logic [ENTRIES-1:0] m_vec, l_vec, n_vec, oldest;
    logic               m_hit, l_hit, n_hit;
    logic [IDX_W-1:0]   m_idx, l_idx, victim, touch_idx;

    mht_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_miss_match (
        .tags(tags), .valid(valid_vec), .key(miss_tag), .vec(m_vec), .hit(m_hit));
    mht_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_look_match (
        .tags(tags), .valid(valid_vec), .key(look_tag), .vec(l_vec), .hit(l_hit));
    mht_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_note_match (
        .tags(tags), .valid(valid_vec), .key(note_tag), .vec(n_vec), .hit(n_hit));

    always_comb begin
        m_idx = '0;
        l_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (m_vec[i]) m_idx = IDX_W'(i);
            if (l_vec[i]) l_idx = IDX_W'(i);
        end
    end

    assign touch_idx = m_hit ? m_idx : victim;

    mht_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk(clk), .rst(rst), .touch(miss_valid), .touch_idx(touch_idx),
        .valid(valid_vec), .victim(victim), .oldest(oldest));

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        upd_e upd;
        always_comb begin
            upd = UPD_NONE;
            if (miss_valid) begin
                if (m_hit)
                    upd = m_vec[i] ? UPD_APPEND : UPD_NONE;
                else if (victim == IDX_W'(i))
                    upd = UPD_ALLOC;
            end
        end

        mht_entry #(.TAG_W(TAG_W), .OFS_W(OFS_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_ent (
            .clk(clk), .rst(rst), .upd(upd),
            .new_tag(miss_tag), .new_ofs(miss_ofs),
            .inc_issue(note_issue && n_hit && n_vec[i]),
            .inc_hit(note_hit && n_hit && n_vec[i]),
            .valid(valid_vec[i]), .tag(tags[i]), .hist(hists[i]),
            .count(counts[i]), .issue_cnt(issues[i]), .hit_cnt(useds[i]));
    end

    assign look_hit       = l_hit;
    assign look_count     = l_hit ? counts[l_idx] : '0;
    assign look_issue_cnt = l_hit ? issues[l_idx] : '0;
    assign look_hit_cnt   = l_hit ? useds[l_idx]  : '0;

    for (genvar k = 0; k < SHOWN; k++) begin : g_show
        assign look_ofs[k*OFS_W +: OFS_W] = l_hit ? hists[l_idx][k] : '0;
    end

endmodule

// File: rtl/mht_checker.sv
module mht_checker #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 46,
    parameter int DEPTH   = 15,
    localparam int CNTH_W = $clog2(DEPTH + 1)
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          miss_valid,
    input logic [TAG_W-1:0]              miss_tag,
    input logic [ENTRIES-1:0]            valid_vec,
    input logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input logic [ENTRIES-1:0]            look_vec,
    input logic [CNTH_W-1:0]             look_count,
    input logic [ENTRIES-1:0]            oldest
);

    logic [TAG_W-1:0] prev_tag;
    logic             resident;

    always_ff @(posedge clk) prev_tag <= miss_tag;

    always_comb begin
        resident = 1'b0;
        for (int i = 0; i < ENTRIES; i++)
            if (valid_vec[i] && tags[i] == prev_tag) resident = 1'b1;
    end

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_vec)); // R2

    AST_SLOTS_KEPT: assert property (@(posedge clk) disable iff (rst)
        $countones(valid_vec) >= $past($countones(valid_vec))); // R3

    AST_MISS_RESIDENT: assert property (@(posedge clk) disable iff (rst)
        miss_valid |=> resident); // R3

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest) == 1); // R4

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        look_count <= CNTH_W'(DEPTH)); // R5

endmodule

bind miss_history_table mht_checker #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .DEPTH(DEPTH)
) u_chk (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_tag(miss_tag),
    .valid_vec(valid_vec), .tags(tags), .look_vec(l_vec),
    .look_count(look_count), .oldest(oldest)
);

// File: tb/tb_miss_history_table.sv
`timescale 1ns/1ps
module tb_miss_history_table;

    localparam int ADDR_W = 64;
    localparam int OFS_W  = 18;
    localparam int E      = 4;
    localparam int D      = 5;
    localparam int CNT_W  = 3;
    localparam int TAG_W  = ADDR_W - OFS_W;
    localparam int CNTH_W = $clog2(D + 1);
    localparam int MAXC   = (1 << CNT_W) - 1;

    logic clk = 0;
    logic rst = 1;
    logic miss_valid = 0;
    logic [ADDR_W-1:0] miss_addr = '0;
    logic [TAG_W-1:0]  look_tag = '0;
    logic [TAG_W-1:0]  note_tag = '0;
    logic note_issue = 0, note_hit = 0;
    logic look_hit;
    logic [CNTH_W-1:0] look_count;
    logic [4*OFS_W-1:0] look_ofs;
    logic [CNT_W-1:0] look_issue_cnt, look_hit_cnt;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    miss_history_table #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .ENTRIES(E), .DEPTH(D), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .look_tag(look_tag), .look_hit(look_hit), .look_count(look_count),
        .look_ofs(look_ofs), .look_issue_cnt(look_issue_cnt), .look_hit_cnt(look_hit_cnt),
        .note_tag(note_tag), .note_issue(note_issue), .note_hit(note_hit));

    // behavioural reference
    bit               mv [E];
    logic [TAG_W-1:0] mt [E];
    logic [OFS_W-1:0] mh [E][$];
    int               mi [E];
    int               mu [E];
    int               order[$];   // front = most recently missed

    function automatic int find(logic [TAG_W-1:0] t);
        for (int i = 0; i < E; i++) if (mv[i] && mt[i] == t) return i;
        return -1;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < E; i++) begin
            mv[i] = 0; mt[i] = '0; mh[i].delete(); mi[i] = 0; mu[i] = 0;
        end
        order.delete();
    endtask

    task automatic model_update(bit m, logic [TAG_W-1:0] t, logic [OFS_W-1:0] o,
                                logic [TAG_W-1:0] nt, bit ni, bit nh);
        int nidx, idx, aidx;
        nidx = find(nt);
        aidx = -1;
        if (m) begin
            idx = find(t);
            if (idx >= 0) begin
                mh[idx].push_front(o);
                if (mh[idx].size() > D) void'(mh[idx].pop_back());
            end else begin
                for (int i = E - 1; i >= 0; i--) if (!mv[i]) aidx = i;
                if (aidx < 0) aidx = order[order.size() - 1];
                mv[aidx] = 1; mt[aidx] = t; mh[aidx].delete(); mh[aidx].push_front(o);
                mi[aidx] = 0; mu[aidx] = 0;
                idx = aidx;
            end
            for (int j = order.size() - 1; j >= 0; j--) if (order[j] == idx) order.delete(j);
            order.push_front(idx);
        end
        if (nidx >= 0 && nidx != aidx) begin
            if (ni && mi[nidx] < MAXC) mi[nidx]++;
            if (nh && mu[nidx] < MAXC) mu[nidx]++;
        end
    endtask

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare(logic [TAG_W-1:0] lt);
        int idx;
        logic [4*OFS_W-1:0] eo;
        idx = find(lt);
        eo = '0;
        if (idx >= 0)
            for (int k = 0; k < 4; k++)
                if (k < mh[idx].size()) eo[k*OFS_W +: OFS_W] = mh[idx][k];
        chk("R6", "look_hit", look_hit, idx >= 0);
        chk("R5", "look_count", look_count, idx >= 0 ? mh[idx].size() : 0);
        chk("R2", "look_ofs", look_ofs, eo);
        chk("R7", "issue_cnt", look_issue_cnt, idx >= 0 ? mi[idx] : 0);
        chk("R8", "hit_cnt", look_hit_cnt, idx >= 0 ? mu[idx] : 0);
    endtask

    task automatic step(bit m, logic [TAG_W-1:0] t, logic [OFS_W-1:0] o,
                        logic [TAG_W-1:0] nt, bit ni, bit nh, logic [TAG_W-1:0] lt);
        miss_valid = m; miss_addr = {t, o};
        note_tag = nt; note_issue = ni; note_hit = nh;
        look_tag = lt;
        model_update(m, t, o, nt, ni, nh);
        @(posedge clk);
        @(negedge clk);
        compare(lt);
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: empty after reset
        chk("R10", "look_hit after reset", look_hit, 0);
        chk("R10", "look_count after reset", look_count, 0);

        // R1: tag/offset split
        step(1, 46'h2A5, 18'h3FFFF, 46'h0, 0, 0, 46'h2A5);
        chk("R1", "offset field", look_ofs[OFS_W-1:0], 18'h3FFFF);
        chk("R1", "tag resident", look_hit, 1);

        // R3: allocation of a new tag
        step(1, 46'h11, 18'h40, 46'h0, 0, 0, 46'h11);
        chk("R3", "count after alloc", look_count, 1);
        chk("R3", "issue after alloc", look_issue_cnt, 0);

        // R2/R5: appends past the depth
        for (int n = 0; n < 7; n++) step(1, 46'h2A5, 18'(n * 8 + 1), 46'h0, 0, 0, 46'h2A5);
        chk("R5", "count saturates", look_count, D);
        chk("R2", "newest offset", look_ofs[OFS_W-1:0], 18'd49);

        // R4: fill, refresh one, notify another, then force replacement
        step(1, 46'h33, 18'h1, 46'h0, 0, 0, 46'h33);
        step(1, 46'h44, 18'h2, 46'h0, 0, 0, 46'h44);
        step(1, 46'h2A5, 18'h3, 46'h11, 1, 1, 46'h11);
        step(0, 46'h0, 18'h0, 46'h0, 0, 0, 46'h11);
        step(1, 46'h55, 18'h4, 46'h0, 0, 0, 46'h11);
        chk("R4", "least recent region replaced", look_hit, 0);
        step(0, 46'h0, 18'h0, 46'h0, 0, 0, 46'h2A5);
        chk("R4", "recent region kept", look_hit, 1);

        // R7/R8: counter saturation
        for (int n = 0; n < 10; n++) step(0, 46'h0, 18'h0, 46'h55, 1, n < 3, 46'h55);
        chk("R7", "issue saturates", look_issue_cnt, MAXC);
        chk("R8", "hit count", look_hit_cnt, 3);

        // R9: notify to an absent tag, and collision with replacement
        step(0, 46'h0, 18'h0, 46'h99, 1, 1, 46'h55);
        chk("R9", "absent notify ignored", look_hit_cnt, 3);
        step(1, 46'h66, 18'h5, 46'h33, 1, 1, 46'h66);
        chk("R9", "new entry counters zero", look_issue_cnt, 0);
        chk("R4", "replaced 33 gone", find(46'h33) < 0, 1);

        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            logic [TAG_W-1:0] t, nt, lt;
            t  = TAG_W'($urandom_range(0, 6));
            nt = TAG_W'($urandom_range(0, 6));
            lt = TAG_W'($urandom_range(0, 6));
            step($urandom_range(0, 3) != 0, t, OFS_W'($urandom), nt,
                 $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, lt);
        end

        // R10: reset clears the table again
        rst = 1;
        miss_valid = 0; note_issue = 0; note_hit = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        model_clear();
        look_tag = 46'h2A5;
        #1;
        chk("R10", "hit after second reset", look_hit, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule